// File: doc/BRIEF.md
# Multiprocessor-Addressable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port behind a small register interface, as found in a microcontroller. One register address serves data in both directions. Writing it loads the transmit shifter and starts a frame. Reading it returns the receive holding register. Frames carry eight data bits, or nine when the wide mode is on. In wide mode the transmitted ninth bit comes from a control bit, and the received ninth bit can be read back from the control register.

The receiver is double-buffered. A finished frame moves into a holding register, and the shifter is then free for the next frame. If a frame lands while the previous byte is still unread, an overrun flag is set. A low stop bit sets a framing-error flag and the frame is dropped.

In wide mode with multiprocessor filtering on, a frame is accepted only when its ninth bit is 1 and its data byte matches a programmable address on the bits chosen by a mask. A received word of all ones always matches, as a broadcast. Receive-complete and transmit-complete flags drive one interrupt line. These flags are cleared only by software. Bit timing comes from an external tick at sixteen times the baud rate.

Top module: `mpuart`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `irq` is 0, and the control register (address 1) and the status register (address 2) read as 0.
- R2: A write to address 0 while the transmitter is idle sends a frame on `txd`. The frame is a start bit 0, then the data bits LSB first, then, in wide mode (control bit 2), the ninth bit from control bit 4, then a stop bit 1. Every bit lasts 16 ticks of `baud_tick`.
- R3: When the stop bit of a frame has been sent, transmit-complete (control bit 1) is set.
- R4: A write to address 0 while a frame is being sent sets transmit-collision (status bit 3). The frame in progress is not changed.
- R5: A received frame with a high stop bit that passes the filter sets receive-complete (control bit 0) and is stored in the holding register, read at address 0. Its ninth bit goes to control bit 5, and that bit is 0 in 8-bit mode.
- R6: When a frame is accepted while the holding register still holds an unread byte, overrun (status bit 0) is set and the holding register takes the new byte. A read of address 0 marks the holding register as read.
- R7: A frame whose stop bit is sampled low sets framing-error (status bit 1). It does not set receive-complete and does not change the holding register.
- R8: With wide mode and filtering (control bit 3) both on, a frame is accepted only if its ninth bit is 1 and either ((byte XOR address) AND mask) is 0, or the 9-bit word is 0x1FF. The address is at address 3 and the mask at address 4; a mask bit of 1 means that bit is compared.
- R9: With filtering off, or in 8-bit mode, every frame with a high stop bit is accepted, whatever its ninth bit.
- R10: A low pulse on `rxd` that is gone by the middle of the start bit is ignored. No flag is set.
- R11: The flags at control bits 0 and 1 and at status bits 0, 1 and 3 are cleared only by writing 1 to them. Writing 0 leaves them set. `irq` is receive-complete OR transmit-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse at 16x the baud rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit data width and 16x oversampling. It drives `baud_tick` every second clock, so one bit lasts 32 cycles and a whole frame fits within a few hundred cycles. At that cost the bench sweeps the filter over a set of ninth-bit-1 words around address 0x5A with mask 0xF0, and predicts each accept or reject by arithmetic. It adds the broadcast word, a matching byte with a zero ninth bit, and transmit frames in both widths. Overrun, framing error, collision and a short false start each come from a scripted line sequence timed in the bench.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MADDR = 3'd3;
    localparam logic [ADDR_W-1:0] REG_MMASK = 3'd4;

    // control register bit positions
    localparam int unsigned C_RXDONE = 0;
    localparam int unsigned C_TXDONE = 1;
    localparam int unsigned C_WIDE   = 2;
    localparam int unsigned C_MPEN   = 3;
    localparam int unsigned C_TXB9   = 4;
    localparam int unsigned C_RXB9   = 5;

    // status register bit positions
    localparam int unsigned S_OVR  = 0;
    localparam int unsigned S_FERR = 1;
    localparam int unsigned S_BUSY = 2;
    localparam int unsigned S_COLL = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
    parameter int unsigned OSR = 16,
    parameter int unsigned DW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          wide,
    input  logic          bit9,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int unsigned FRM_W = DW + 3;
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(FRM_W + 1);

    typedef struct packed {
        logic             busy;
        logic [FRM_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] left;
        logic             done;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (load) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                if (wide) begin
                    d.sh   = {1'b1, bit9, data, 1'b0};
                    d.left = IDX_W'(FRM_W);
                end else begin
                    d.sh   = {2'b11, data, 1'b0};
                    d.left = IDX_W'(FRM_W - 1);
                end
            end
        end else if (tick) begin
            if (q.cnt == CNT_W'(OSR - 1)) begin
                d.cnt  = '0;
                d.sh   = {1'b1, q.sh[FRM_W-1:1]};
                d.left = q.left - 1'b1;
                if (q.left == IDX_W'(1)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign txd  = q.busy ? q.sh[0] : 1'b1;
    assign busy = q.busy;
    assign done = q.done;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int unsigned OSR = 16,
    parameter int unsigned DW  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        rxd,
    input  logic        wide,
    output logic        frame_vld,
    output logic [DW:0] frame_word,
    output logic        stop_ok
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(DW + 2);

    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DW:0]      sh;
        logic             vld;
        logic [DW:0]      word;
        logic             stop_ok;
    } rx_st_t;

    rx_st_t q, d;
    logic   line;
    logic   mid;

    assign line = q.sync[1];
    assign mid  = tick && (q.cnt == CNT_W'(OSR - 1));

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.sync = {q.sync[0], rxd};
        unique case (q.st)
            RX_IDLE: begin
                if (!line) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == CNT_W'(OSR / 2 - 1)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.sh  = '0;
                        d.st  = line ? RX_IDLE : RX_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (mid) begin
                    d.cnt = '0;
                    d.sh  = {line, q.sh[DW:1]};
                    d.idx = q.idx + 1'b1;
                    if (q.idx == (wide ? IDX_W'(DW) : IDX_W'(DW - 1)))
                        d.st = RX_STOP;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (mid) begin
                    d.vld     = 1'b1;
                    d.stop_ok = line;
                    d.word    = wide ? q.sh : {1'b0, q.sh[DW:1]};
                    d.st      = RX_IDLE;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.st   <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign frame_vld  = q.vld;
    assign frame_word = q.word;
    assign stop_ok    = q.stop_ok;
endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter #(
    parameter int unsigned DW = 8
) (
    input  logic [DW:0]   word,
    input  logic [DW-1:0] match_addr,
    input  logic [DW-1:0] match_mask,
    output logic          hit
);
    logic addr_eq;
    logic bcast;

    assign addr_eq = ((word[DW-1:0] ^ match_addr) & match_mask) == '0;
    assign bcast   = &word;
    assign hit     = (word[DW] && addr_eq) || bcast;
endmodule

// File: rtl/mpuart.sv
module mpuart
    import mpuart_pkg::*;
#(
    parameter int unsigned OSR = 16,
    parameter int unsigned DW  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic          full;
        logic          rb8;
        logic          rx_done;
        logic          tx_done;
        logic          wide;
        logic          mpen;
        logic          tb8;
        logic          ovr;
        logic          ferr;
        logic          coll;
        logic [DW-1:0] maddr;
        logic [DW-1:0] mmask;
    } regs_t;

    regs_t q, d;

    logic          tx_busy, tx_fin, tx_load;
    logic          frame_vld, stop_ok, hit, accept;
    logic [DW:0]   frame_word;
    logic          wr_data, rd_data;

    assign wr_data = wr_en && (addr == REG_DATA);
    assign rd_data = rd_en && (addr == REG_DATA);
    assign tx_load = wr_data && !tx_busy;

    mpuart_tx #(.OSR(OSR), .DW(DW)) tx_i (
        .clk(clk), .rst(rst), .tick(baud_tick), .load(tx_load),
        .data(wdata), .wide(q.wide), .bit9(q.tb8),
        .txd(txd), .busy(tx_busy), .done(tx_fin)
    );

    mpuart_rx #(.OSR(OSR), .DW(DW)) rx_i (
        .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd), .wide(q.wide),
        .frame_vld(frame_vld), .frame_word(frame_word), .stop_ok(stop_ok)
    );

    mpuart_filter #(.DW(DW)) flt_i (
        .word(frame_word), .match_addr(q.maddr), .match_mask(q.mmask), .hit(hit)
    );

    assign accept = frame_vld && stop_ok && (!(q.wide && q.mpen) || hit);

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (addr)
                REG_DATA:  if (tx_busy) d.coll = 1'b1;
                REG_CTRL: begin
                    d.wide = wdata[C_WIDE];
                    d.mpen = wdata[C_MPEN];
                    d.tb8  = wdata[C_TXB9];
                    if (wdata[C_RXDONE]) d.rx_done = 1'b0;
                    if (wdata[C_TXDONE]) d.tx_done = 1'b0;
                end
                REG_STAT: begin
                    if (wdata[S_OVR])  d.ovr  = 1'b0;
                    if (wdata[S_FERR]) d.ferr = 1'b0;
                    if (wdata[S_COLL]) d.coll = 1'b0;
                end
                REG_MADDR: d.maddr = wdata;
                REG_MMASK: d.mmask = wdata;
                default: ;
            endcase
        end
        if (rd_data) d.full = 1'b0;
        if (tx_fin) d.tx_done = 1'b1;
        if (frame_vld && !stop_ok) d.ferr = 1'b1;
        if (accept) begin
            if (q.full && !rd_data) d.ovr = 1'b1;
            d.hold    = frame_word[DW-1:0];
            d.rb8     = frame_word[DW];
            d.rx_done = 1'b1;
            d.full    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_DATA:  rdata = q.hold;
            REG_CTRL: begin
                rdata[C_RXDONE] = q.rx_done;
                rdata[C_TXDONE] = q.tx_done;
                rdata[C_WIDE]   = q.wide;
                rdata[C_MPEN]   = q.mpen;
                rdata[C_TXB9]   = q.tb8;
                rdata[C_RXB9]   = q.rb8;
            end
            REG_STAT: begin
                rdata[S_OVR]  = q.ovr;
                rdata[S_FERR] = q.ferr;
                rdata[S_BUSY] = tx_busy;
                rdata[S_COLL] = q.coll;
            end
            REG_MADDR: rdata = q.maddr;
            REG_MMASK: rdata = q.mmask;
            default:   rdata = '0;
        endcase
    end

    assign irq = q.rx_done || q.tx_done;
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk
    import mpuart_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic              txd,
    input logic              irq,
    input logic              tx_busy,
    input logic              coll,
    input logic              tx_done,
    input logic              full,
    input logic              ovr,
    input logic              accept
);
    // R2
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R4
    coll_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_DATA && tx_busy) |=> coll);

    // R3
    txdone_set_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |=> tx_done);

    // R11
    txdone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !(wr_en && addr == REG_CTRL && wdata[C_TXDONE])) |=> tx_done);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en && addr == REG_CTRL));

    // R6
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && full && !(rd_en && addr == REG_DATA)) |=> ovr);
endmodule

bind mpuart mpuart_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .txd(txd), .irq(irq), .tx_busy(tx_busy),
    .coll(q.coll), .tx_done(q.tx_done), .full(q.full), .ovr(q.ovr),
    .accept(accept)
);

// File: tb/mpuart_tb.sv
module mpuart_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam int BIT_CLK = 32;

    always #2.5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    mpuart dut_i (
        .clk(clk), .rst(rst), .baud_tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic send_rx(input logic [8:0] w, input bit wide, input bit stopb);
        @(negedge clk); rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = w[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        if (wide) begin
            rxd = w[8];
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = stopb;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLK * 2) @(negedge clk);
    endtask

    task automatic cap_tx(input bit wide, output logic [7:0] dat,
                          output logic b9, output logic stopb, output logic startb);
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (BIT_CLK / 2) @(negedge clk);
        startb = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            dat[i] = txd;
        end
        b9 = 1'b0;
        if (wide) begin
            repeat (BIT_CLK) @(negedge clk);
            b9 = txd;
        end
        repeat (BIT_CLK) @(negedge clk);
        stopb = txd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, dat;
        logic b9, sb, st;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 irq", int'(irq), 0);
        peek(3'd1, v); chk("R1 ctrl", int'(v), 0);
        peek(3'd2, v); chk("R1 stat", int'(v), 0);

        // R2/R3: transmit sweep, 8-bit and wide frames
        for (int k = 0; k < 6; k++) begin
            bit wide = (k >= 3);
            bit t9 = k[0];
            logic [7:0] val = 8'(k * 37 + 5);
            wr(3'd1, {3'b000, t9, 1'b0, wide, 2'b11});
            wr(3'd0, val);
            cap_tx(wide, dat, b9, sb, st);
            chk("R2 start", int'(st), 0);
            chk("R2 data", int'(dat), int'(val));
            chk("R2 bit9", int'(b9), wide ? int'(t9) : 0);
            chk("R2 stop", int'(sb), 1);
            repeat (BIT_CLK) @(negedge clk);
            peek(3'd1, v); chk("R3 txdone", int'(v[1]), 1);
            chk("R11 irq", int'(irq), 1);
        end

        // R11: writing 0 keeps the flag, writing 1 clears it
        wr(3'd1, 8'h00);
        peek(3'd1, v); chk("R11 keep", int'(v[1]), 1);
        wr(3'd1, 8'h02);
        peek(3'd1, v); chk("R11 clear", int'(v[1]), 0);
        chk("R11 irq low", int'(irq), 0);

        // R4: collision during transmit
        wr(3'd0, 8'hA5);
        repeat (100) @(negedge clk);
        wr(3'd0, 8'h3C);
        peek(3'd2, v); chk("R4 coll", int'(v[3]), 1);
        chk("R4 busy", int'(v[2]), 1);
        begin
            logic [7:0] acc;
            acc = 8'h00;
            // remaining bits of the first frame: mid of bit 3 onward
            while (!(txd === 1'b1 && rdata[2] == 1'b0)) begin
                @(negedge clk); addr = 3'd2; #1;
            end
        end
        wr(3'd2, 8'h08);
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h5E);
        cap_tx(1'b0, dat, b9, sb, st);
        chk("R4 next frame ok", int'(dat), 8'h5E);
        repeat (BIT_CLK) @(negedge clk);
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h81);
        repeat (BIT_CLK * 3 + 8) @(negedge clk);
        wr(3'd0, 8'h00);
        cap_tx(1'b0, dat, b9, sb, st);
        repeat (BIT_CLK) @(negedge clk);
        peek(3'd2, v); chk("R4 coll again", int'(v[3]), 1);
        wr(3'd2, 8'h08);
        wr(3'd1, 8'h02);

        // R5/R9: 8-bit receive, filtering bit set but ignored in 8-bit mode
        wr(3'd1, 8'h08);
        send_rx(9'h012, 1'b0, 1'b1);
        peek(3'd1, v); chk("R9 8bit accept", int'(v[0]), 1);
        chk("R5 rb8 8bit", int'(v[5]), 0);
        rd(3'd0, v); chk("R5 data", int'(v), 8'h12);

        // R6: two frames without read
        wr(3'd1, 8'h01);
        send_rx(9'h033, 1'b0, 1'b1);
        send_rx(9'h0C4, 1'b0, 1'b1);
        peek(3'd2, v); chk("R6 overrun", int'(v[0]), 1);
        rd(3'd0, v); chk("R6 newest", int'(v), 8'hC4);
        wr(3'd2, 8'h01);
        send_rx(9'h077, 1'b0, 1'b1);
        peek(3'd2, v); chk("R6 no overrun after read", int'(v[0]), 0);
        rd(3'd0, v);

        // R7: framing error
        wr(3'd1, 8'h01);
        send_rx(9'h0E1, 1'b0, 1'b0);
        peek(3'd2, v); chk("R7 ferr", int'(v[1]), 1);
        peek(3'd1, v); chk("R7 no rxdone", int'(v[0]), 0);
        peek(3'd0, v); chk("R7 hold kept", int'(v), 8'h77);
        wr(3'd2, 8'h02);

        // R10: false start
        @(negedge clk); rxd = 1'b0;
        repeat (6) @(negedge clk); rxd = 1'b1;
        repeat (BIT_CLK * 12) @(negedge clk);
        peek(3'd1, v); chk("R10 no rxdone", int'(v[0]), 0);
        peek(3'd2, v); chk("R10 no flags", int'(v[1:0]), 0);

        // R9: wide mode, filter off, ninth bit 0 accepted
        wr(3'd1, 8'h04);
        send_rx(9'h0AB, 1'b1, 1'b1);
        peek(3'd1, v); chk("R9 wide accept", int'(v[0]), 1);
        chk("R5 rb8 zero", int'(v[5]), 0);
        rd(3'd0, v); chk("R9 data", int'(v), 8'hAB);

        // R8: filter sweep, address 0x5A mask 0xF0
        wr(3'd3, 8'h5A);
        wr(3'd4, 8'hF0);
        for (int i = 0; i < 19; i++) begin
            logic [8:0] w;
            bit exp_hit;
            if (i < 16)       w = {1'b1, 4'(i), 4'((i * 5) & 15)};
            else if (i == 16) w = 9'h1FF;
            else if (i == 17) w = 9'h05A;
            else              w = 9'h15F;
            exp_hit = w[8] && ((w[7:0] & 8'hF0) == 8'h50) || (w == 9'h1FF);
            wr(3'd1, 8'h0D);
            send_rx(w, 1'b1, 1'b1);
            peek(3'd1, v);
            chk($sformatf("R8 filter word %0h", w), int'(v[0]), int'(exp_hit));
            if (exp_hit) begin
                chk("R5 rb8 one", int'(v[5]), 1);
                rd(3'd0, v); chk("R8 hold", int'(v), int'(w[7:0]));
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule